// File: doc/BRIEF.md
# Read-Modify-Write Shift, Rotate and Step Unit

This unit carries out the data side of an 8-bit processor's read-modify-write instructions. It covers shift left, rotate left, shift right, rotate right, increment and decrement. The caller has already resolved the effective address. It presents that address with a one-cycle `start` pulse and an operation code. The unit then runs three bus cycles on that address: it reads the operand, makes one dummy access, and writes the modified value back. When it finishes, it reports N, Z and C.

The same unit also runs the accumulator forms. In that case it makes a single dummy read at the program counter, and the new accumulator value appears on `acc_out` together with a write strobe. The `CMOS` parameter selects the dummy-access style. With `CMOS = 0` the dummy cycle writes the unmodified operand back. With `CMOS = 1` it is a plain re-read. Increment and decrement of the accumulator exist only when `CMOS = 1`.

The bus is a simple synchronous-write port. `bus_rdata` must return the byte at `bus_addr` within the same cycle, and a write takes effect at the clock edge that ends a cycle with `bus_act` and `bus_we` both high.

Top module: `rmw_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `bus_act`, `bus_we`, `acc_we` and `flag_we` are all low.
- R2: A memory operation accepted at clock edge E0 drives `bus_act` with `bus_addr` = `eff_addr` for the three cycles after E0.
  - In the first of those cycles, `bus_we` is low.
  - In the third, `bus_we` is high and `bus_wdata` carries the result.
  - `done` is high in the fourth cycle after E0.
- R3: The middle (dummy) cycle of a memory operation writes the unmodified operand when `CMOS` = 0, and reads with `bus_we` low when `CMOS` = 1. A memory operation therefore makes two writes with `CMOS` = 0 and one with `CMOS` = 1.
- R4: Operation code 0 (shift left) gives {a[6:0],0}, and code 1 (rotate left) gives {a[6:0],carry_in}. Both set C to a[7].
- R5: Operation code 2 (shift right) gives {0,a[7:1]}, and code 3 (rotate right) gives {carry_in,a[7:1]}. Both set C to a[0].
- R6: Operation code 4 (increment) and code 5 (decrement) wrap modulo 256, and they return C equal to `carry_in`.
- R7: On completion, `flag_we` pulses together with `done`, with N = bit 7 of the result and Z = 1 exactly when the result is zero.
- R8: With `acc_mode` high, the operand is `acc_in`. The unit makes exactly one access: a read at `pc` in the cycle after E0. In the following cycle, `done` and `acc_we` are high and `acc_out` holds the result. No memory write occurs.
- R9: With `CMOS` = 0, a `start` with `acc_mode` high and operation code 4 or 5 is ignored: no bus access, `busy` stays low, and no `done` follows.
- R10: A `start` while `busy` is high is ignored. A `start` with operation code 6 or 7 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| op_sel | input | 3 | 0 shl, 1 rol, 2 shr, 3 ror, 4 inc, 5 dec |
| acc_mode | input | 1 | 1 = accumulator form |
| eff_addr | input | 16 | Resolved effective address |
| pc | input | 16 | Program counter for the accumulator dummy read |
| acc_in | input | 8 | Accumulator value |
| carry_in | input | 1 | Current carry flag |
| bus_rdata | input | 8 | Read data for `bus_addr`, same cycle |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_act | output | 1 | A bus access occurs this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator update strobe |
| flag_n | output | 1 | Negative flag result |
| flag_z | output | 1 | Zero flag result |
| flag_c | output | 1 | Carry flag result |
| flag_we | output | 1 | Flag update strobe |

## Verification
The bound checker watches, on every cycle:
- the quiet state after reset;
- the address holding steady across one operation;
- the single-write rule of the re-reading variant;
- the pairing of `flag_we` and `acc_we` with `done`;
- the refusal of unknown codes and of blocked accumulator steps.

Only the bench's scenarios can show the actual result values and carry for each operation, the order and contents of the writes, and the cycle in which `done` arrives. The bench runs every vector on one instance of each variant side by side with its own memory model, so the two dummy-cycle styles are compared on identical stimulus.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_ROL = 3'd1,
    OP_SHR = 3'd2,
    OP_ROR = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5
  } rmw_op_e;

  localparam int unsigned RMW_OP_COUNT = 6;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_WRITE = 3'd3,
    ST_ACC   = 3'd4
  } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rmw_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    res   = a;
    c_out = cin;
    case (op)
      OP_SHL: begin
        res   = {a[DATA_W-2:0], 1'b0};
        c_out = a[DATA_W-1];
      end
      OP_ROL: begin
        res   = {a[DATA_W-2:0], cin};
        c_out = a[DATA_W-1];
      end
      OP_SHR: begin
        res   = {1'b0, a[DATA_W-1:1]};
        c_out = a[0];
      end
      OP_ROR: begin
        res   = {cin, a[DATA_W-1:1]};
        c_out = a[0];
      end
      OP_INC: res = a + ONE;
      OP_DEC: res = a - ONE;
      default: begin
        res   = a;
        c_out = cin;
      end
    endcase
    n_out = res[DATA_W-1];
    z_out = (res == '0);
  end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter bit CMOS   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic              acc_mode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic              alu_c,
  output rmw_op_e           alu_op,
  output logic [DATA_W-1:0] alu_a,
  output logic              alu_cin,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_act,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_we
);

  rmw_state_e        state_q;
  rmw_op_e           op_q;
  logic              cin_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] res_q;
  logic              n_q, z_q, c_q;

  logic op_known, op_step, acc_blocked, accept;

  always_comb begin
    op_known    = (32'(op_sel) < RMW_OP_COUNT);
    op_step     = (op_sel == OP_INC) || (op_sel == OP_DEC);
    acc_blocked = acc_mode && op_step && !CMOS;
    accept      = start && op_known && !acc_blocked && (state_q == ST_IDLE);
  end

  assign alu_op  = op_q;
  assign alu_cin = cin_q;
  assign alu_a   = (state_q == ST_ACC) ? acc_q : bus_rdata;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_SHL;
      cin_q     <= 1'b0;
      acc_q     <= '0;
      res_q     <= '0;
      n_q       <= 1'b0;
      z_q       <= 1'b0;
      c_q       <= 1'b0;
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
      bus_act   <= 1'b0;
      done      <= 1'b0;
      acc_out   <= '0;
      acc_we    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
      flag_we   <= 1'b0;
    end else begin
      done    <= 1'b0;
      acc_we  <= 1'b0;
      flag_we <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= rmw_op_e'(op_sel);
            cin_q   <= carry_in;
            acc_q   <= acc_in;
            bus_act <= 1'b1;
            bus_we  <= 1'b0;
            if (acc_mode) begin
              bus_addr <= pc;
              state_q  <= ST_ACC;
            end else begin
              bus_addr <= eff_addr;
              state_q  <= ST_READ;
            end
          end
        end
        ST_READ: begin
          res_q     <= alu_res;
          n_q       <= alu_n;
          z_q       <= alu_z;
          c_q       <= alu_c;
          bus_we    <= !CMOS;
          bus_wdata <= bus_rdata;
          state_q   <= ST_DUMMY;
        end
        ST_DUMMY: begin
          bus_we    <= 1'b1;
          bus_wdata <= res_q;
          state_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          bus_act <= 1'b0;
          bus_we  <= 1'b0;
          done    <= 1'b1;
          flag_we <= 1'b1;
          flag_n  <= n_q;
          flag_z  <= z_q;
          flag_c  <= c_q;
          state_q <= ST_IDLE;
        end
        ST_ACC: begin
          bus_act <= 1'b0;
          done    <= 1'b1;
          acc_we  <= 1'b1;
          acc_out <= alu_res;
          flag_we <= 1'b1;
          flag_n  <= alu_n;
          flag_z  <= alu_z;
          flag_c  <= alu_c;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rmw_unit.sv
module rmw_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter bit CMOS   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic              acc_mode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_act,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_we
);

  rmw_op_e           alu_op;
  logic [DATA_W-1:0] alu_a;
  logic              alu_cin;
  logic [DATA_W-1:0] alu_res;
  logic              alu_n, alu_z, alu_c;

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (alu_op),
    .a     (alu_a),
    .cin   (alu_cin),
    .res   (alu_res),
    .n_out (alu_n),
    .z_out (alu_z),
    .c_out (alu_c)
  );

  rmw_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CMOS(CMOS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_sel    (op_sel),
    .acc_mode  (acc_mode),
    .eff_addr  (eff_addr),
    .pc        (pc),
    .acc_in    (acc_in),
    .carry_in  (carry_in),
    .bus_rdata (bus_rdata),
    .alu_res   (alu_res),
    .alu_n     (alu_n),
    .alu_z     (alu_z),
    .alu_c     (alu_c),
    .alu_op    (alu_op),
    .alu_a     (alu_a),
    .alu_cin   (alu_cin),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_act   (bus_act),
    .busy      (busy),
    .done      (done),
    .acc_out   (acc_out),
    .acc_we    (acc_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_we   (flag_we)
  );

endmodule

// File: rtl/rmw_unit_chk.sv
module rmw_unit_chk #(
  parameter int ADDR_W = 16,
  parameter bit CMOS   = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        op_sel,
  input logic              acc_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_act,
  input logic              busy,
  input logic              done,
  input logic              acc_we,
  input logic              flag_we
);

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !bus_act && !acc_we && !flag_we)); // R1

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_act && $past(bus_act)) |-> $stable(bus_addr)); // R2

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(busy) && !bus_act)); // R2

  AST_REREAD_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (CMOS && bus_act && bus_we) |=> !bus_we); // R3

  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> done); // R7

  AST_ACC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> (done && !bus_act)); // R8

  AST_ACC_STEP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!CMOS && start && !busy && acc_mode && (op_sel == 3'd4 || op_sel == 3'd5))
      |=> (!busy && !bus_act)); // R9

  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op_sel > 3'd5) |=> (!busy && !bus_act)); // R10

endmodule

bind rmw_unit rmw_unit_chk #(.ADDR_W(ADDR_W), .CMOS(CMOS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .op_sel   (op_sel),
  .acc_mode (acc_mode),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_act  (bus_act),
  .busy     (busy),
  .done     (done),
  .acc_we   (acc_we),
  .flag_we  (flag_we)
);

// File: tb/rmw_unit_test.sv
`timescale 1ns/1ps
module rmw_unit_test;

  localparam int NV = 14;
  // {op[2:0], acc_mode, operand[7:0], carry_in, result[7:0], carry_out}
  localparam logic [21:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'h81, 1'b0, 8'h02, 1'b1},
    {3'd1, 1'b0, 8'h81, 1'b1, 8'h03, 1'b1},
    {3'd2, 1'b0, 8'h01, 1'b0, 8'h00, 1'b1},
    {3'd3, 1'b0, 8'h01, 1'b1, 8'h80, 1'b1},
    {3'd4, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b1},
    {3'd5, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0},
    {3'd3, 1'b0, 8'hFE, 1'b0, 8'h7F, 1'b0},
    {3'd5, 1'b0, 8'h80, 1'b1, 8'h7F, 1'b1},
    {3'd0, 1'b1, 8'h40, 1'b1, 8'h80, 1'b0},
    {3'd3, 1'b1, 8'h02, 1'b0, 8'h01, 1'b0},
    {3'd1, 1'b1, 8'h00, 1'b1, 8'h01, 1'b0},
    {3'd2, 1'b1, 8'hFE, 1'b1, 8'h7F, 1'b0},
    {3'd4, 1'b1, 8'h7F, 1'b0, 8'h80, 1'b0},
    {3'd5, 1'b1, 8'h01, 1'b1, 8'h00, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic        acc_mode = 1'b0;
  logic [15:0] eff_addr = 16'h0;
  logic [15:0] pc = 16'h0800;
  logic [7:0]  acc_in = 8'h0;
  logic        carry_in = 1'b0;

  always #4 clk = ~clk;

  logic [15:0] n_addr, c_addr;
  logic        n_we, c_we, n_act, c_act, n_busy, c_busy, n_done, c_done;
  logic [7:0]  n_wdata, c_wdata, n_rdata, c_rdata, n_acc, c_acc;
  logic        n_accwe, c_accwe, n_fn, c_fn, n_fz, c_fz, n_fc, c_fc, n_fwe, c_fwe;

  logic [7:0]  mem_n [256];
  logic [7:0]  mem_c [256];
  logic        pre_en = 1'b0;
  logic [7:0]  pre_a = 8'h0;
  logic [7:0]  pre_v = 8'h0;
  int          n_acnt = 0, c_acnt = 0, n_wcnt = 0, c_wcnt = 0;
  logic [7:0]  n_hist [4];
  logic [7:0]  c_hist [4];
  logic [15:0] n_last = 16'h0, c_last = 16'h0;

  assign n_rdata = mem_n[n_addr[7:0]];
  assign c_rdata = mem_c[c_addr[7:0]];

  rmw_unit #(.CMOS(1'b0)) uut (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .acc_mode(acc_mode),
    .eff_addr(eff_addr), .pc(pc), .acc_in(acc_in), .carry_in(carry_in),
    .bus_rdata(n_rdata), .bus_addr(n_addr), .bus_we(n_we), .bus_wdata(n_wdata),
    .bus_act(n_act), .busy(n_busy), .done(n_done), .acc_out(n_acc),
    .acc_we(n_accwe), .flag_n(n_fn), .flag_z(n_fz), .flag_c(n_fc), .flag_we(n_fwe)
  );

  rmw_unit #(.CMOS(1'b1)) uut_cm (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .acc_mode(acc_mode),
    .eff_addr(eff_addr), .pc(pc), .acc_in(acc_in), .carry_in(carry_in),
    .bus_rdata(c_rdata), .bus_addr(c_addr), .bus_we(c_we), .bus_wdata(c_wdata),
    .bus_act(c_act), .busy(c_busy), .done(c_done), .acc_out(c_acc),
    .acc_we(c_accwe), .flag_n(c_fn), .flag_z(c_fz), .flag_c(c_fc), .flag_we(c_fwe)
  );

  always @(posedge clk) begin
    if (pre_en) begin
      mem_n[pre_a] <= pre_v;
      mem_c[pre_a] <= pre_v;
    end
    if (n_act) begin
      n_acnt <= n_acnt + 1;
      n_last <= n_addr;
      if (n_we) begin
        mem_n[n_addr[7:0]] <= n_wdata;
        n_hist[n_wcnt % 4] <= n_wdata;
        n_wcnt <= n_wcnt + 1;
      end
    end
    if (c_act) begin
      c_acnt <= c_acnt + 1;
      c_last <= c_addr;
      if (c_we) begin
        mem_c[c_addr[7:0]] <= c_wdata;
        c_hist[c_wcnt % 4] <= c_wdata;
        c_wcnt <= c_wcnt + 1;
      end
    end
  end

  int  total = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_a = a; pre_v = v;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [2:0] op; logic accm, cin, cout; logic [7:0] val, res;
    logic [15:0] ea;
    int n_a0, c_a0, n_w0, c_w0, dn_n, dn_c;
    logic [7:0] a_n, a_c; logic [2:0] f_n, f_c;
    string rq;
    {op, accm, val, cin, res, cout} = VEC[i];
    ea = 16'h1240 + 16'(i);
    rq = (op < 3'd2) ? "R4" : (op < 3'd4) ? "R5" : "R6";
    preload(ea[7:0], val);
    n_a0 = n_acnt; c_a0 = c_acnt; n_w0 = n_wcnt; c_w0 = c_wcnt;
    dn_n = 0; dn_c = 0; a_n = 8'h0; a_c = 8'h0; f_n = 3'b0; f_c = 3'b0;
    start = 1'b1; op_sel = op; acc_mode = accm; eff_addr = ea;
    acc_in = val; carry_in = cin;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      if (n_done && dn_n == 0) begin
        dn_n = k; a_n = n_acc; f_n = {n_fn, n_fz, n_fc};
        chk("R7", "flag_we with done nmos", 16'(n_fwe), 16'd1);
      end
      if (c_done && dn_c == 0) begin
        dn_c = k; a_c = c_acc; f_c = {c_fn, c_fz, c_fc};
        chk("R7", "flag_we with done cmos", 16'(c_fwe), 16'd1);
      end
    end
    if (!accm) begin
      chk("R2", "done cycle nmos", 16'(dn_n), 16'd4);
      chk("R2", "done cycle cmos", 16'(dn_c), 16'd4);
      chk("R2", "access count cmos", 16'(c_acnt - c_a0), 16'd3);
      chk("R2", "write address nmos", n_last, ea);
      chk(rq, "memory result nmos", 16'(mem_n[ea[7:0]]), 16'(res));
      chk(rq, "memory result cmos", 16'(mem_c[ea[7:0]]), 16'(res));
      chk("R3", "write count nmos", 16'(n_wcnt - n_w0), 16'd2);
      chk("R3", "dummy write value nmos", 16'(n_hist[n_w0 % 4]), 16'(val));
      chk("R3", "write count cmos", 16'(c_wcnt - c_w0), 16'd1);
      chk(rq, "carry nmos", 16'(f_n[0]), 16'(cout));
      chk("R7", "N Z nmos", 16'(f_n[2:1]), 16'({res[7], res == 8'h0}));
      chk("R7", "N Z cmos", 16'(f_c[2:1]), 16'({res[7], res == 8'h0}));
    end else begin
      chk("R8", "done cycle cmos", 16'(dn_c), 16'd2);
      chk("R8", "access count cmos", 16'(c_acnt - c_a0), 16'd1);
      chk("R8", "dummy read address cmos", c_last, pc);
      chk("R8", "no write cmos", 16'(c_wcnt - c_w0), 16'd0);
      chk(rq, "acc result cmos", 16'(a_c), 16'(res));
      chk(rq, "carry cmos", 16'(f_c[0]), 16'(cout));
      chk("R7", "N Z cmos", 16'(f_c[2:1]), 16'({res[7], res == 8'h0}));
      if (op >= 3'd4) begin
        chk("R9", "nmos acc step no done", 16'(dn_n), 16'd0);
        chk("R9", "nmos acc step no access", 16'(n_acnt - n_a0), 16'd0);
      end else begin
        chk("R8", "done cycle nmos", 16'(dn_n), 16'd2);
        chk(rq, "acc result nmos", 16'(a_n), 16'(res));
        chk("R8", "no write nmos", 16'(n_wcnt - n_w0), 16'd0);
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", 16'(n_busy | c_busy), 16'd0);
    chk("R1", "done after reset", 16'(n_done | c_done), 16'd0);
    chk("R1", "bus_act after reset", 16'(n_act | c_act | n_we | c_we), 16'd0);
    chk("R1", "strobes after reset", 16'(n_accwe | c_accwe | n_fwe | c_fwe), 16'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: start while busy must not retarget the operation
    preload(8'h60, 8'h11);
    preload(8'h61, 8'h22);
    begin
      int a0;
      a0 = c_acnt;
      start = 1'b1; op_sel = 3'd0; acc_mode = 1'b0; eff_addr = 16'h1260; carry_in = 1'b0;
      @(negedge clk);
      eff_addr = 16'h1261;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10", "busy start target untouched", 16'(mem_c[8'h61]), 16'h22);
      chk("R10", "first target updated", 16'(mem_c[8'h60]), 16'h22);
      chk("R10", "access count busy start", 16'(c_acnt - a0), 16'd3);
    end

    // R10: unknown operation code 7
    begin
      int a0;
      a0 = n_acnt + c_acnt;
      start = 1'b1; op_sel = 3'd7; eff_addr = 16'h1262;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "unknown op busy", 16'(n_busy | c_busy), 16'd0);
      repeat (3) @(negedge clk);
      chk("R10", "unknown op accesses", 16'(n_acnt + c_acnt - a0), 16'd0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule